// File: doc/BRIEF.md
# Sensor Heater Contrast Controller

This block runs the heater of a swept thermal image sensor in closed loop. The sensor reports a 4-bit temperature code once per frame. Code 8 means no difference from the reference. The steps are nonlinear, and codes 0 and 15 are saturated. Because the code is only a relative measure, the controller works on differences. When low image contrast is flagged upstream, it waits for the next frame's code and latches that code as a baseline. It then raises the heater enable until a later code has climbed a configured number of steps above that baseline.

A heating interval ends in one of two ways: the target is reached, or a frame-count timeout expires. After either, a cool-down hold of a set number of frames passes before the next request is accepted. Requests that arrive while a cycle is under way are dropped. A baseline at the top of the scale cannot show any rise, so that case is refused and flagged. A nap command forces the heater off at once and returns the controller to idle. Contrast measurement is done elsewhere and reaches this block only as a request pulse.

Top module: `heater_loop_top`

## Requirements
- R1: After reset, heatEn, waitBase, cooling, errSat, timedOut and reached are all 0.
- R2: In idle, a lowContrastReq with napCmd low moves the block to the baseline wait (waitBase=1) in the next cycle. The next frame (codeValid=1) latches codeIn into baseCode. If that code is below 15, heatEn is 1 from the cycle after that frame.
- R3: A baseline frame with code 15 (4'b1111) never raises heatEn. It sets errSat and returns the block to idle.
- R4: The target is the baseline plus riseSteps, capped at 15. Heating ends on the first heating frame whose code is at least the target, and that frame sets reached. Frames below the target, including falling codes, keep the heater on.
- R5: Let N be timeoutFrames, with 0 treated as 1. If N heating frames pass without meeting the target, heatEn drops after the Nth of them and timedOut is set.
- R6: If the target is met on the same frame that the timeout would expire, the result is reached, not timedOut.
- R7: A lowContrastReq during the baseline wait, heating or cool-down has no effect on state or outputs.
- R8: After heating ends, cooling stays 1 for coolFrames valid frames, and only after that is a request accepted. A coolFrames of 0 returns the block to idle on the next cycle.
- R9: While napCmd is 1, heatEn is 0 in the same cycle. The controller is in idle from the next cycle, and requests are ignored.
- R10: errSat, timedOut and reached hold their values until the next request is accepted, which clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| codeIn | input | CODE_W | Per-frame temperature code |
| codeValid | input | 1 | One-cycle strobe marking a new frame code |
| lowContrastReq | input | 1 | Request to warm the sensor |
| napCmd | input | 1 | Nap command; forces the heater off |
| riseSteps | input | CODE_W | Code steps to gain above the baseline |
| timeoutFrames | input | CNT_W | Heating frame limit |
| coolFrames | input | CNT_W | Cool-down hold in frames |
| heatEn | output | 1 | Heater enable |
| waitBase | output | 1 | Waiting for the baseline frame |
| cooling | output | 1 | In the cool-down hold |
| baseCode | output | CODE_W | Latched baseline code |
| errSat | output | 1 | Baseline was saturated; request refused |
| timedOut | output | 1 | Last interval hit the timeout |
| reached | output | 1 | Last interval reached the target |

## Verification
The sweep covers every non-saturated baseline against rises of 0 to 4, with a timeout of 3. This exposes three kinds of bug: a target that wraps past 15 instead of capping, so heating stops at once or never; a timeout that is off by one frame; and the wrong flag winning when the target and the timeout land on the same frame. Requests are pulsed during heating and during the cool-down. A design that accepted them would restart the cycle or end the hold early. Nap is asserted mid-heat to catch an enable that lags by a cycle. The saturated baseline, a zero hold and a zero timeout each get a directed case.

// File: rtl/heater_pkg.sv
package heater_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_HEAT = 2'd2,
    ST_COOL = 2'd3
  } heatState_e;

  typedef struct packed {
    logic latchBase;
    logic clrCnt;
    logic incCnt;
    logic selCool;
  } dpCtl_t;
endpackage

// File: rtl/heater_datapath.sv
module heater_datapath
  import heater_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [CODE_W-1:0] codeIn,
  input  logic [CODE_W-1:0] riseSteps,
  input  logic [CNT_W-1:0]  timeoutFrames,
  input  logic [CNT_W-1:0]  coolFrames,
  output logic [CODE_W-1:0] baseCode,
  output logic              codeSat,
  output logic              targetMet,
  output logic              windowEnd,
  output logic              coolZero
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic [CODE_W:0]   targetSum;
  logic [CODE_W-1:0] targetCode;
  logic [CNT_W-1:0]  frameCnt;
  logic [CNT_W:0]    cntNext;
  logic [CNT_W-1:0]  limit;

  // saturating target
  assign targetSum  = {1'b0, baseCode} + {1'b0, riseSteps};
  assign targetCode = targetSum[CODE_W] ? CODE_MAX : targetSum[CODE_W-1:0];
  assign targetMet  = codeIn >= targetCode;
  assign codeSat    = codeIn == CODE_MAX;

  assign limit     = ctl.selCool ? coolFrames : timeoutFrames;
  assign cntNext   = {1'b0, frameCnt} + 1'b1;
  assign windowEnd = cntNext >= {1'b0, limit};
  assign coolZero  = coolFrames == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCode <= '0;
    end else if (ctl.latchBase) begin
      baseCode <= codeIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
    end else if (ctl.clrCnt) begin
      frameCnt <= '0;
    end else if (ctl.incCnt) begin
      frameCnt <= cntNext[CNT_W-1:0];
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.selCool && frameCnt != '0) |-> (frameCnt < timeoutFrames));
endmodule

// File: rtl/heater_control.sv
module heater_control
  import heater_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   codeValid,
  input  logic   lowContrastReq,
  input  logic   napCmd,
  input  logic   codeSat,
  input  logic   targetMet,
  input  logic   windowEnd,
  input  logic   coolZero,
  output dpCtl_t ctl,
  output logic   heatEn,
  output logic   waitBase,
  output logic   cooling,
  output logic   errSat,
  output logic   timedOut,
  output logic   reached
);
  heatState_e state, stateNext;
  logic setErr, setTimeout, setReached, clrFlags;

  always_comb begin
    stateNext     = state;
    ctl.latchBase = 1'b0;
    ctl.incCnt    = 1'b0;
    setErr        = 1'b0;
    setTimeout    = 1'b0;
    setReached    = 1'b0;
    clrFlags      = 1'b0;
    if (napCmd) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (lowContrastReq) begin
          stateNext = ST_ARM;
          clrFlags  = 1'b1;
        end
        ST_ARM: if (codeValid) begin
          if (codeSat) begin
            stateNext = ST_IDLE;
            setErr    = 1'b1;
          end else begin
            stateNext     = ST_HEAT;
            ctl.latchBase = 1'b1;
          end
        end
        ST_HEAT: if (codeValid) begin
          if (targetMet) begin
            stateNext  = ST_COOL;
            setReached = 1'b1;
          end else if (windowEnd) begin
            stateNext  = ST_COOL;
            setTimeout = 1'b1;
          end else begin
            ctl.incCnt = 1'b1;
          end
        end
        ST_COOL: begin
          if (coolZero) begin
            stateNext = ST_IDLE;
          end else if (codeValid) begin
            if (windowEnd) stateNext = ST_IDLE;
            else ctl.incCnt = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
    ctl.clrCnt  = stateNext != state;
    ctl.selCool = state == ST_COOL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      errSat   <= 1'b0;
      timedOut <= 1'b0;
      reached  <= 1'b0;
    end else begin
      state <= stateNext;
      if (clrFlags) begin
        errSat   <= 1'b0;
        timedOut <= 1'b0;
        reached  <= 1'b0;
      end else begin
        if (setErr)     errSat   <= 1'b1;
        if (setTimeout) timedOut <= 1'b1;
        if (setReached) reached  <= 1'b1;
      end
    end
  end

  assign heatEn   = (state == ST_HEAT) && !napCmd;
  assign waitBase = state == ST_ARM;
  assign cooling  = state == ST_COOL;

  // R9
  nap_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    napCmd |=> (state == ST_IDLE));
  // R3
  sat_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARM && codeValid && codeSat && !napCmd) |=> (errSat && state == ST_IDLE));
  // R7
  req_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HEAT && lowContrastReq && !codeValid && !napCmd) |=> (state == ST_HEAT));
  // R2
  heat_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_HEAT) ##1 (state == ST_HEAT) |-> $past(state) == ST_ARM);
  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(timedOut && reached));
endmodule

// File: rtl/heater_loop_top.sv
module heater_loop_top
  import heater_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              codeValid,
  input  logic              lowContrastReq,
  input  logic              napCmd,
  input  logic [CODE_W-1:0] riseSteps,
  input  logic [CNT_W-1:0]  timeoutFrames,
  input  logic [CNT_W-1:0]  coolFrames,
  output logic              heatEn,
  output logic              waitBase,
  output logic              cooling,
  output logic [CODE_W-1:0] baseCode,
  output logic              errSat,
  output logic              timedOut,
  output logic              reached
);
  dpCtl_t ctl;
  logic codeSat, targetMet, windowEnd, coolZero;

  heater_datapath #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .codeIn(codeIn),
    .riseSteps(riseSteps), .timeoutFrames(timeoutFrames),
    .coolFrames(coolFrames), .baseCode(baseCode), .codeSat(codeSat),
    .targetMet(targetMet), .windowEnd(windowEnd), .coolZero(coolZero)
  );

  heater_control u_ctl (
    .clk(clk), .rstN(rstN), .codeValid(codeValid),
    .lowContrastReq(lowContrastReq), .napCmd(napCmd), .codeSat(codeSat),
    .targetMet(targetMet), .windowEnd(windowEnd), .coolZero(coolZero),
    .ctl(ctl), .heatEn(heatEn), .waitBase(waitBase), .cooling(cooling),
    .errSat(errSat), .timedOut(timedOut), .reached(reached)
  );
endmodule

// File: tb/heater_loop_top_bench.sv
`timescale 1ns/1ps
module heater_loop_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  codeIn = '0;
  logic        codeValid = 1'b0;
  logic        lowContrastReq = 1'b0;
  logic        napCmd = 1'b0;
  logic [3:0]  riseSteps = 4'd2;
  logic [15:0] timeoutFrames = 16'd3;
  logic [15:0] coolFrames = 16'd2;
  logic        heatEn, waitBase, cooling, errSat, timedOut, reached;
  logic [3:0]  baseCode;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  heater_loop_top u_heater_loop_top (
    .clk(clk), .rstN(rstN), .codeIn(codeIn), .codeValid(codeValid),
    .lowContrastReq(lowContrastReq), .napCmd(napCmd), .riseSteps(riseSteps),
    .timeoutFrames(timeoutFrames), .coolFrames(coolFrames), .heatEn(heatEn),
    .waitBase(waitBase), .cooling(cooling), .baseCode(baseCode),
    .errSat(errSat), .timedOut(timedOut), .reached(reached)
  );

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic frame(input int code);
    codeIn = code[3:0];
    codeValid = 1'b1;
    tick();
    codeValid = 1'b0;
  endtask

  task automatic request();
    lowContrastReq = 1'b1;
    tick();
    lowContrastReq = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state
    check({heatEn, waitBase, cooling, errSat, timedOut, reached}, 0, "R1");
    rstN = 1'b1;
    tick();

    // Sweep baselines and rises; timeout 3, cool hold 2
    for (int b = 0; b < 15; b++) begin
      for (int r = 0; r < 5; r++) begin
        int kTgt, kHit, kEnd, tgt;
        riseSteps = r[3:0];
        request();
        check(waitBase, 1, "R2 wait");
        check({errSat, timedOut, reached}, 0, "R10 clear");
        frame(b);
        check(baseCode, b, "R2 base");
        check(heatEn, 1, "R2 heat on");
        tgt  = (b + r > 15) ? 15 : b + r;
        kTgt = (tgt - b < 1) ? 1 : tgt - b;
        kHit = kTgt;
        kEnd = (kHit < 3) ? kHit : 3;
        for (int k = 1; k <= kEnd; k++) begin
          if (k == 1) begin
            request();
            check(heatEn, 1, "R7 heat");
          end
          frame((b + k > 15) ? 15 : b + k);
          check(heatEn, (k < kEnd) ? 1 : 0, "R4 heat");
        end
        check(reached, (kHit <= 3) ? 1 : 0, "R4 R6 reached");
        check(timedOut, (kHit > 3) ? 1 : 0, "R5 timedOut");
        request();
        check({cooling, heatEn, waitBase}, 3'b100, "R8 R7 cool");
        frame(8);
        check(cooling, 1, "R8 hold");
        frame(8);
        check(cooling, 0, "R8 release");
      end
    end

    // R4 falling code keeps heater on
    riseSteps = 4'd2; timeoutFrames = 16'd5;
    request(); frame(8);
    frame(6);
    check(heatEn, 1, "R4 falling");
    frame(10);
    check(reached, 1, "R4 hit");
    frame(8); frame(8);

    // R3 saturated baseline
    request(); frame(15);
    check(errSat, 1, "R3 err");
    check({heatEn, waitBase, cooling}, 0, "R3 idle");
    tick();
    check(heatEn, 0, "R3 no heat");

    // R9 nap mid-heat
    request();
    check(errSat, 0, "R10 err clear");
    frame(4);
    napCmd = 1'b1;
    #1;
    check(heatEn, 0, "R9 immediate");
    tick();
    check({heatEn, waitBase, cooling}, 0, "R9 idle");
    request();
    check(waitBase, 0, "R9 req ignored");
    napCmd = 1'b0;
    frame(4);
    check(heatEn, 0, "R9 stays off");

    // R8 zero hold, R5 zero timeout
    coolFrames = 16'd0; timeoutFrames = 16'd0; riseSteps = 4'd4;
    request(); frame(3);
    frame(4);
    check(timedOut, 1, "R5 zero timeout");
    check(cooling, 1, "R8 cool");
    tick();
    check(cooling, 0, "R8 zero hold");
    request();
    check(waitBase, 1, "R8 accept");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule